// File: doc/BRIEF.md
# Secure Region Access Checker

This block judges each data access of a core that runs in a secure or a normal world, each with kernel and user privilege. Software programs a small table of regions. Each region has an arbitrary lower bound and upper bound, a world tag (secure or normal), a secure ID and three permission bits. Regions must never overlap. A table write that would overlap another live region is refused, and a sticky configuration-error flag is raised.

For every access the core presents the following:
- the address
- whether the access is a read or a write
- the current world and privilege
- the secure ID, world and privilege of the instruction fetch that issued the access

One cycle later the block answers with either grant or violation. An access is granted only when all of these hold:
- it falls inside a live region
- the region's world tag admits the current world
- the fetch's secure ID equals the region's secure ID
- the fetch's world and privilege equal those of the access
- the region's permission bits allow the access type and privilege

Top module: `secure_region_guard`

## Requirements
- R1: After reset, grant, violation and cfg_err are 0, and every region is disabled, so any access is answered with a violation.
- R2: A region covers addresses from lo (inclusive) up to hi (exclusive), with no size or alignment restriction. An address equal to hi, or below lo, does not match the region.
- R3: A region whose hi is not greater than its lo is disabled. It matches no address and never takes part in an overlap.
- R4: A write that gives an enabled region a range intersecting another enabled region leaves the table unchanged and sets cfg_err. cfg_err stays 1 until reset.
- R5: A region tagged secure (cfg_secure=1) grants only when acc_secure=1. A region tagged normal may grant in either world.
- R6: An access is denied unless acc_fetch_sid equals the matched region's secure ID.
- R7: An access is denied unless acc_fetch_secure equals acc_secure and acc_fetch_user equals acc_user.
- R8: The permission bits are: bit 0 allows reads, bit 1 allows writes, bit 2 allows user privilege (acc_user=1). An access lacking the needed bit is denied.
- R9: An access matching no enabled region is denied with a violation.
- R10: One cycle after acc_valid=1, exactly one of grant and violation is 1. After a cycle with acc_valid=0, both are 0.
- R11: When a table write and an access arrive in the same cycle, the access is judged against the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IW | Region index to write |
| cfg_lo | input | AW | Lower bound, inclusive |
| cfg_hi | input | AW | Upper bound, exclusive |
| cfg_secure | input | 1 | Region world tag, 1 = secure |
| cfg_sid | input | IDW | Region secure ID |
| cfg_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 user |
| acc_valid | input | 1 | Access request |
| acc_addr | input | AW | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_secure | input | 1 | Current world, 1 = secure |
| acc_user | input | 1 | Current privilege, 1 = user |
| acc_fetch_sid | input | IDW | Secure ID of the issuing instruction fetch |
| acc_fetch_secure | input | 1 | World of the issuing fetch |
| acc_fetch_user | input | 1 | Privilege of the issuing fetch |
| grant | output | 1 | Access allowed (registered) |
| violation | output | 1 | Access refused (registered) |
| cfg_err | output | 1 | Sticky flag for a refused overlapping write |

## Verification
A table write and an access can land in the same cycle. The block must then judge the access against the old table while it commits or refuses the write. The bench provokes this directly: it disables a region in the same cycle as an access that hits that region. It expects a grant in that cycle and a violation on the next access. During the random phase, writes and accesses are issued together. A bench model applies each write only after computing the expected verdict, so both outcomes and cfg_err are compared every cycle.

// File: rtl/secure_region_guard.sv
module secure_region_guard #(
  parameter int AW   = 32,
  parameter int NREG = 4,
  parameter int IDW  = 4,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_idx,
  input  logic [AW-1:0]  cfg_lo,
  input  logic [AW-1:0]  cfg_hi,
  input  logic           cfg_secure,
  input  logic [IDW-1:0] cfg_sid,
  input  logic [2:0]     cfg_perm,
  input  logic           acc_valid,
  input  logic [AW-1:0]  acc_addr,
  input  logic           acc_write,
  input  logic           acc_secure,
  input  logic           acc_user,
  input  logic [IDW-1:0] acc_fetch_sid,
  input  logic           acc_fetch_secure,
  input  logic           acc_fetch_user,
  output logic           grant,
  output logic           violation,
  output logic           cfg_err
);

  logic [AW-1:0]  r_lo   [NREG];
  logic [AW-1:0]  r_hi   [NREG];
  logic           r_sec  [NREG];
  logic [IDW-1:0] r_sid  [NREG];
  logic [2:0]     r_perm [NREG];

  logic [NREG-1:0] live, hit, clash_v;
  logic            sel_sec;
  logic [IDW-1:0]  sel_sid;
  logic [2:0]      sel_perm;

  wire new_live = cfg_hi > cfg_lo;

  always_comb begin
    sel_sec  = 1'b0;
    sel_sid  = '0;
    sel_perm = '0;
    for (int i = 0; i < NREG; i++) begin
      live[i]    = r_hi[i] > r_lo[i];
      hit[i]     = live[i] && acc_addr >= r_lo[i] && acc_addr < r_hi[i];
      clash_v[i] = (IW'(i) != cfg_idx) && live[i] && new_live &&
                   cfg_lo < r_hi[i] && r_lo[i] < cfg_hi;
      if (hit[i]) begin
        sel_sec  = sel_sec  | r_sec[i];
        sel_sid  = sel_sid  | r_sid[i];
        sel_perm = sel_perm | r_perm[i];
      end
    end
  end

  wire clash    = |clash_v;
  wire world_ok = !sel_sec || acc_secure;
  wire sid_ok   = sel_sid == acc_fetch_sid;
  wire mode_ok  = (acc_fetch_secure == acc_secure) && (acc_fetch_user == acc_user);
  wire perm_ok  = (acc_write ? sel_perm[1] : sel_perm[0]) && (!acc_user || sel_perm[2]);
  wire allow    = |hit && world_ok && sid_ok && mode_ok && perm_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        r_lo[i]   <= '0;
        r_hi[i]   <= '0;
        r_sec[i]  <= 1'b0;
        r_sid[i]  <= '0;
        r_perm[i] <= '0;
      end
      grant     <= 1'b0;
      violation <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      grant     <= acc_valid && allow;
      violation <= acc_valid && !allow;
      if (cfg_we) begin
        if (clash) begin
          cfg_err <= 1'b1;
        end else begin
          r_lo[cfg_idx]   <= cfg_lo;
          r_hi[cfg_idx]   <= cfg_hi;
          r_sec[cfg_idx]  <= cfg_secure;
          r_sid[cfg_idx]  <= cfg_sid;
          r_perm[cfg_idx] <= cfg_perm;
        end
      end
    end
  end

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && violation));
  a_r10_answer: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (grant || violation));
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!grant && !violation));
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  a_r4_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && clash) |=> cfg_err);
  a_r4_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  a_r5_secure_only: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && sel_sec && !acc_secure) |=> violation);
  a_r9_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hit == '0) |=> violation);

endmodule

// File: tb/secure_region_guard_tb.sv
module secure_region_guard_tb;
  localparam int AW = 32, NREG = 4, IDW = 4, IW = 2;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [IW-1:0] cfg_idx = 0;
  logic [AW-1:0] cfg_lo = 0, cfg_hi = 0;
  logic cfg_secure = 0; logic [IDW-1:0] cfg_sid = 0; logic [2:0] cfg_perm = 0;
  logic acc_valid = 0; logic [AW-1:0] acc_addr = 0;
  logic acc_write = 0, acc_secure = 0, acc_user = 0;
  logic [IDW-1:0] acc_fetch_sid = 0;
  logic acc_fetch_secure = 0, acc_fetch_user = 0;
  logic grant, violation, cfg_err;

  always #4 clk = ~clk;

  secure_region_guard #(.AW(AW), .NREG(NREG), .IDW(IDW)) u_dut (.*);

  int checks = 0, errors = 0;
  logic [AW-1:0]  m_lo [NREG], m_hi [NREG];
  logic           m_sec [NREG];
  logic [IDW-1:0] m_sid [NREG];
  logic [2:0]     m_perm [NREG];
  logic           m_err = 0;

  function automatic bit model_ok();
    for (int i = 0; i < NREG; i++)
      if (m_hi[i] > m_lo[i] && acc_addr >= m_lo[i] && acc_addr < m_hi[i])
        return (!m_sec[i] || acc_secure) && m_sid[i] == acc_fetch_sid &&
               acc_fetch_secure == acc_secure && acc_fetch_user == acc_user &&
               (acc_write ? m_perm[i][1] : m_perm[i][0]) && (!acc_user || m_perm[i][2]);
    return 0;
  endfunction

  function automatic bit model_clash();
    if (!(cfg_hi > cfg_lo)) return 0;
    for (int i = 0; i < NREG; i++)
      if (i != int'(cfg_idx) && m_hi[i] > m_lo[i] && cfg_lo < m_hi[i] && m_lo[i] < cfg_hi)
        return 1;
    return 0;
  endfunction

  task automatic check(bit ok, string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: {err,viol,grant} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic run(string tag);
    logic g, v;
    bit ok;
    ok = model_ok();
    g = acc_valid && ok;
    v = acc_valid && !ok;
    if (cfg_we) begin
      if (model_clash()) m_err = 1;
      else begin
        m_lo[cfg_idx] = cfg_lo; m_hi[cfg_idx] = cfg_hi; m_sec[cfg_idx] = cfg_secure;
        m_sid[cfg_idx] = cfg_sid; m_perm[cfg_idx] = cfg_perm;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check({cfg_err, violation, grant} === {m_err, v, g}, tag,
          {cfg_err, violation, grant}, {m_err, v, g});
    cfg_we = 0;
    acc_valid = 0;
  endtask

  task automatic wr(int idx, int lo, int hi, bit sec, int sid, int perm);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_lo = AW'(lo); cfg_hi = AW'(hi);
    cfg_secure = sec; cfg_sid = IDW'(sid); cfg_perm = 3'(perm);
  endtask

  task automatic ac(int addr, bit w, bit s, bit u, int fsid, bit fs, bit fu);
    acc_valid = 1; acc_addr = AW'(addr); acc_write = w; acc_secure = s; acc_user = u;
    acc_fetch_sid = IDW'(fsid); acc_fetch_secure = fs; acc_fetch_user = fu;
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NREG; i++) begin
      m_lo[i] = 0; m_hi[i] = 0; m_sec[i] = 0; m_sid[i] = 0; m_perm[i] = 0;
    end
    repeat (3) @(negedge clk);
    check({cfg_err, violation, grant} === 3'b000, "R1 reset", {cfg_err, violation, grant}, 3'b000);
    rst_n = 1;
    @(negedge clk);
    ac(8'h10, 0, 0, 0, 0, 0, 0); run("R1 empty table denies");

    wr(0, 8'h10, 8'h20, 0, 1, 7); run("R2 write r0");
    ac(8'h10, 0, 0, 1, 1, 0, 1); run("R2 lo inclusive");
    ac(8'h1F, 1, 0, 0, 1, 0, 0); run("R2 last addr");
    ac(8'h20, 0, 0, 0, 1, 0, 0); run("R2 hi exclusive");
    ac(8'h0F, 0, 0, 0, 1, 0, 0); run("R9 below lo");

    wr(1, 8'h40, 8'h53, 1, 2, 1); run("R2 write r1 odd size");
    ac(8'h52, 0, 1, 0, 2, 1, 0); run("R5 secure kernel read grant");
    ac(8'h45, 0, 0, 0, 2, 0, 0); run("R5 normal world denied");
    ac(8'h15, 0, 1, 0, 1, 1, 0); run("R5 normal region from secure");
    ac(8'h45, 0, 1, 0, 3, 1, 0); run("R6 sid mismatch");
    ac(8'h45, 0, 1, 0, 2, 1, 1); run("R7 fetch privilege mismatch");
    ac(8'h15, 0, 0, 0, 1, 1, 0); run("R7 fetch world mismatch");
    ac(8'h45, 1, 1, 0, 2, 1, 0); run("R8 write to read-only");
    ac(8'h45, 0, 1, 1, 2, 1, 1); run("R8 user without user bit");

    wr(2, 8'h60, 8'h60, 0, 0, 7); run("R3 empty region write");
    ac(8'h60, 0, 0, 0, 0, 0, 0); run("R3 empty region miss");
    wr(2, 8'h18, 8'h12, 0, 0, 7); run("R3 inverted not clash");
    ac(8'h15, 0, 0, 0, 0, 0, 0); run("R3 inverted no hit");

    wr(0, 0, 0, 0, 0, 0); ac(8'h12, 0, 0, 0, 1, 0, 0); run("R11 old table used");
    ac(8'h12, 0, 0, 0, 1, 0, 0); run("R11 new table next");

    wr(0, 8'h10, 8'h20, 0, 1, 7); run("R2 rewrite r0");
    wr(3, 8'h1F, 8'h41, 0, 5, 7); run("R4 overlap rejected");
    ac(8'h30, 0, 0, 0, 5, 0, 0); run("R4 table unchanged");
    wr(3, 8'h20, 8'h40, 0, 5, 7); run("R4 abutting accepted, err sticky");
    ac(8'h30, 0, 0, 0, 5, 0, 0); run("R4 abutting region live");

    for (int n = 0; n < 400; n++) begin
      int k;
      k = int'($urandom_range(NREG - 1));
      if ($urandom_range(2) == 0)
        wr(k, int'($urandom_range(255)), int'($urandom_range(255)), 1'($urandom),
           int'($urandom_range(3)), int'($urandom_range(7)));
      if ($urandom_range(3) != 0) begin
        bit s, u;
        s = 1'($urandom); u = 1'($urandom);
        if ($urandom_range(1) == 0)
          ac(int'($urandom_range(255)), 1'($urandom), s, u, int'(m_sid[k]), s, u);
        else
          ac(int'($urandom_range(255)), 1'($urandom), s, u, int'($urandom_range(3)),
             1'($urandom), 1'($urandom));
      end
      run("R10 random mix");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule